// File: doc/BRIEF.md
# Transport Header Exception Checker

This block inspects the transport-layer header of a received IP packet and reports at most one exception for each packet. The header arrives one byte per cycle with a valid qualifier and with start and end markers. Alongside the first byte, side inputs say whether the segment is UDP or TCP, how many IP payload bytes remain after the IP header, whether the packet is a fragment, and whether an earlier stage has already reported an error. An externally computed 16-bit checksum seed, which covers the pseudo-header and any payload not streamed here, is also supplied with the first byte.

The block extracts the two port numbers, the UDP length and checksum fields and the TCP flag byte. It folds every streamed byte into a ones'-complement sum together with the seed. One cycle after the end byte is accepted, it evaluates the exception rules in a fixed priority. The next cycle it presents a registered error flag and a 4-bit code with a one-cycle done strobe. Fragments and packets that already carry an error are passed through with no error raised.

Top module: `l4_hdr_check`

## Requirements
- R1: `done` is high for exactly one cycle, two rising edges after the edge that accepts the byte with `in_eop` set. `err` and `err_code` change only in that cycle and hold their values until the next `done`.
- R2: When `is_frag` or `prior_err` was high with the start byte, the result is `err`=0 and `err_code`=0 whatever the header holds.
- R3: The ones'-complement sum is formed from the seed and the streamed bytes taken as big-endian 16-bit words, with a lone last byte padded with a zero low byte. When this sum is not 0xFFFF, the result is code 2.
- R4: For UDP (`is_udp`=1), a checksum field of zero at byte offsets 6 and 7 disables the code 2 check.
- R5: For UDP, the length field at byte offsets 4 (high) and 5 (low) gives code 3 when it is greater than `ip_remain`. Equal or smaller values raise no error.
- R6: The source port is at byte offsets 0 and 1 and the destination port at offsets 2 and 3, both big-endian. A port value of zero gives code 4.
- R7: For TCP, the flag byte is at offset 13, with FIN at bit 0, SYN at bit 1, RST at bit 2 and URG at bit 5. Bits 7 and 6 are ignored. When FIN is the only one of bits 5:0 set, the result is code 8. When bits 5:0 are all zero, the result is code 9.
- R8: For TCP, the following flag pairs, with both flags set, give these codes: FIN and RST give 10, SYN and URG give 11, SYN and RST give 12, SYN and FIN give 13.
- R9: When several conditions hold, the lowest code wins: checksum (2), then UDP length (3), then port (4), then the TCP flag codes in ascending order.
- R10: After reset, `done`, `err` and `err_code` are 0. A packet with no exception reports `err`=0 and `err_code`=0.
- R11: `is_udp`, `ip_remain`, `is_frag`, `prior_err` and `csum_seed` are sampled only with the start byte. Changes during the rest of the packet have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Header byte valid |
| in_sop | input | 1 | First byte of the header |
| in_eop | input | 1 | Last byte of the header |
| in_byte | input | 8 | Header byte |
| is_udp | input | 1 | 1 = UDP, 0 = TCP (sampled with start byte) |
| ip_remain | input | 16 | IP payload bytes after the IP header (sampled with start byte) |
| is_frag | input | 1 | Packet is a fragment (sampled with start byte) |
| prior_err | input | 1 | Earlier stage already flagged an error (sampled with start byte) |
| csum_seed | input | 16 | Partial checksum from outside (sampled with start byte) |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Exception detected |
| err_code | output | 4 | Exception code, 0 when none |

## Verification
The bench sweeps all 64 combinations of the six low TCP flag bits, with the ignored upper bits varied. A design that mixes up a bit position or a pair priority gives a wrong code in one of those rows. The UDP length is stepped across `ip_remain`, with the boundary at equality. An off-by-one comparison reports code 3 for a legal datagram. Odd-length headers test the zero padding of the last byte. A zero UDP checksum field paired with a wrong seed shows whether the skip works. Stacked faults test the priority order: a design checking in the wrong order reports a higher code. Fragments and prior-error packets carrying every fault must come out clean. A packet whose side inputs change after the start byte shows whether they were sampled late.

// File: rtl/l4chk_pkg.sv
// Package: shared codes, header offsets and ones'-complement helper for the
// transport header exception checker.
package l4chk_pkg;

    typedef enum logic [3:0] {
        EC_NONE     = 4'd0,
        EC_CSUM     = 4'd2,
        EC_ULEN     = 4'd3,
        EC_PORT     = 4'd4,
        EC_FIN_ONLY = 4'd8,
        EC_NO_FLAGS = 4'd9,
        EC_FIN_RST  = 4'd10,
        EC_SYN_URG  = 4'd11,
        EC_SYN_RST  = 4'd12,
        EC_SYN_FIN  = 4'd13
    } l4_err_e;

    // Byte offsets the decode depends on
    localparam int OFF_SRC_HI  = 0;
    localparam int OFF_SRC_LO  = 1;
    localparam int OFF_DST_HI  = 2;
    localparam int OFF_DST_LO  = 3;
    localparam int OFF_ULEN_HI = 4;
    localparam int OFF_ULEN_LO = 5;
    localparam int OFF_UCS_HI  = 6;
    localparam int OFF_UCS_LO  = 7;
    localparam int OFF_TFLAGS  = 13;

    // TCP flag bit positions within the flag byte
    localparam int FL_FIN = 0;
    localparam int FL_SYN = 1;
    localparam int FL_RST = 2;
    localparam int FL_URG = 5;

    // 16-bit ones'-complement addition with end-around carry
    function automatic logic [15:0] ones_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

endpackage

// File: rtl/l4chk_capture.sv
// Module: l4chk_capture
// Counts header bytes from the start marker, extracts ports, UDP length and
// checksum fields and the TCP flag bits, and samples the side inputs with the
// start byte. Assumes the header is at least long enough to hold the fields
// it needs; missing fields read as zero. last_q pulses the cycle after the
// end byte is accepted.
module l4chk_capture #(
    parameter int IDX_W = 6,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [7:0]       in_byte,
    input  logic             is_udp,
    input  logic [LEN_W-1:0] ip_remain,
    input  logic             is_frag,
    input  logic             prior_err,
    output logic             last_q,
    output logic             kind_udp_q,
    output logic             gate_q,
    output logic [LEN_W-1:0] remain_q,
    output logic [15:0]      src_q,
    output logic [15:0]      dst_q,
    output logic [15:0]      ulen_q,
    output logic [15:0]      ucs_q,
    output logic [5:0]       flags_q
);
    import l4chk_pkg::*;

    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_cur;

    // Position of the byte on the bus within the current header
    always_comb idx_cur = in_sop ? '0 : idx_q;

    // Byte counter, saturating so long headers never wrap onto field offsets
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (in_valid)
            idx_q <= (idx_cur == IDX_MAX) ? idx_cur : idx_cur + IDX_W'(1);
    end

    // End-of-header pulse for the classifier
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= in_valid && in_eop;
    end

    // Side inputs, sampled only with the start byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_udp_q <= 1'b0;
            gate_q     <= 1'b0;
            remain_q   <= '0;
        end else if (in_valid && in_sop) begin
            kind_udp_q <= is_udp;
            gate_q     <= is_frag || prior_err;
            remain_q   <= ip_remain;
        end
    end

    // Field extraction by byte offset; fields are cleared at each start byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            dst_q   <= '0;
            ulen_q  <= '0;
            ucs_q   <= '0;
            flags_q <= '0;
        end else if (in_valid) begin
            if (in_sop) begin
                src_q   <= '0;
                dst_q   <= '0;
                ulen_q  <= '0;
                ucs_q   <= '0;
                flags_q <= '0;
            end
            case (idx_cur)
                IDX_W'(OFF_SRC_HI):  src_q[15:8]  <= in_byte;
                IDX_W'(OFF_SRC_LO):  src_q[7:0]   <= in_byte;
                IDX_W'(OFF_DST_HI):  dst_q[15:8]  <= in_byte;
                IDX_W'(OFF_DST_LO):  dst_q[7:0]   <= in_byte;
                IDX_W'(OFF_ULEN_HI): ulen_q[15:8] <= in_byte;
                IDX_W'(OFF_ULEN_LO): ulen_q[7:0]  <= in_byte;
                IDX_W'(OFF_UCS_HI):  ucs_q[15:8]  <= in_byte;
                IDX_W'(OFF_UCS_LO):  ucs_q[7:0]   <= in_byte;
                IDX_W'(OFF_TFLAGS):  flags_q      <= in_byte[5:0];
                default: ;
            endcase
        end
    end

    // R11: a byte other than the start byte leaves the sampled gate alone
    p_side_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sop) |=> $stable(gate_q) && $stable(kind_udp_q));

endmodule

// File: rtl/l4chk_csum.sv
// Module: l4chk_csum
// Folds the seed and the streamed bytes, paired big-endian into 16-bit words,
// into a ones'-complement sum. A lone last byte is padded with a zero low
// byte. sum_ok is meaningful in the cycle after the end byte.
module l4chk_csum (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic [7:0]  in_byte,
    input  logic [15:0] csum_seed,
    output logic        sum_ok
);
    import l4chk_pkg::*;

    logic [15:0] acc_q;
    logic [7:0]  hi_q;
    logic        odd_q;
    logic        odd_cur;
    logic [15:0] base;

    // Word-half tracking and accumulator starting point for this byte
    always_comb begin
        odd_cur = in_sop ? 1'b0 : odd_q;
        base    = in_sop ? csum_seed : acc_q;
    end

    // Accumulate one word per byte pair, padding an unpaired end byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            hi_q  <= '0;
            odd_q <= 1'b0;
        end else if (in_valid) begin
            odd_q <= !odd_cur;
            if (odd_cur) begin
                acc_q <= ones_add(base, {hi_q, in_byte});
            end else begin
                hi_q  <= in_byte;
                acc_q <= in_eop ? ones_add(base, {in_byte, 8'h00}) : base;
            end
        end
    end

    // Valid sum folds to all ones
    always_comb sum_ok = (acc_q == 16'hFFFF);

endmodule

// File: rtl/l4chk_classify.sv
// Module: l4chk_classify
// Applies the exception rules in priority order to the captured fields and
// registers the flag, the code and a one-cycle done strobe. Assumes all
// inputs are stable in the cycle last_q is high.
module l4chk_classify #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             last_q,
    input  logic             kind_udp_q,
    input  logic             gate_q,
    input  logic [LEN_W-1:0] remain_q,
    input  logic [15:0]      src_q,
    input  logic [15:0]      dst_q,
    input  logic [15:0]      ulen_q,
    input  logic [15:0]      ucs_q,
    input  logic [5:0]       flags_q,
    input  logic             sum_ok,
    output logic             done,
    output logic             err,
    output logic [3:0]       err_code
);
    import l4chk_pkg::*;

    l4_err_e code_c;
    logic    fin, syn, rst, urg;
    logic    csum_bad;

    // Priority selection: lowest code wins
    always_comb begin
        fin      = flags_q[FL_FIN];
        syn      = flags_q[FL_SYN];
        rst      = flags_q[FL_RST];
        urg      = flags_q[FL_URG];
        csum_bad = !sum_ok && !(kind_udp_q && (ucs_q == 16'd0));
        if (csum_bad)                                           code_c = EC_CSUM;
        else if (kind_udp_q && (LEN_W'(ulen_q) > remain_q))     code_c = EC_ULEN;
        else if ((src_q == 16'd0) || (dst_q == 16'd0))          code_c = EC_PORT;
        else if (kind_udp_q)                                    code_c = EC_NONE;
        else if (flags_q == 6'b000001)                          code_c = EC_FIN_ONLY;
        else if (flags_q == 6'b000000)                          code_c = EC_NO_FLAGS;
        else if (fin && rst)                                    code_c = EC_FIN_RST;
        else if (syn && urg)                                    code_c = EC_SYN_URG;
        else if (syn && rst)                                    code_c = EC_SYN_RST;
        else if (syn && fin)                                    code_c = EC_SYN_FIN;
        else                                                    code_c = EC_NONE;
    end

    // Result registers, updated only when a header has just ended
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            err      <= 1'b0;
            err_code <= '0;
        end else begin
            done <= last_q;
            if (last_q) begin
                err      <= !gate_q && (code_c != EC_NONE);
                err_code <= gate_q ? 4'd0 : 4'(code_c);
            end
        end
    end

    // R2: gated packets never raise an error
    p_gated_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(gate_q)) |-> !err);

    // R9: a reported code is one of the defined values
    p_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (err_code inside {4'd2, 4'd3, 4'd4, [4'd8:4'd13]}));

    // R7: UDP datagrams never get a TCP flag code
    p_udp_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err && $past(kind_udp_q)) |-> (err_code <= 4'd4));

    // R10: a clear flag goes with a zero code
    p_clean_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !err |-> (err_code == 4'd0));

endmodule

// File: rtl/l4_hdr_check.sv
// Module: l4_hdr_check (top)
// Transport header exception checker: byte capture, checksum accumulation and
// priority classification. Assumes one header at a time and a start byte that
// comes after the previous header's end byte.
module l4_hdr_check #(
    parameter int IDX_W = 6,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [7:0]       in_byte,
    input  logic             is_udp,
    input  logic [LEN_W-1:0] ip_remain,
    input  logic             is_frag,
    input  logic             prior_err,
    input  logic [15:0]      csum_seed,
    output logic             done,
    output logic             err,
    output logic [3:0]       err_code
);
    logic             last_q, kind_udp_q, gate_q, sum_ok;
    logic [LEN_W-1:0] remain_q;
    logic [15:0]      src_q, dst_q, ulen_q, ucs_q;
    logic [5:0]       flags_q;

    l4chk_capture #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_byte(in_byte), .is_udp(is_udp),
        .ip_remain(ip_remain), .is_frag(is_frag), .prior_err(prior_err),
        .last_q(last_q), .kind_udp_q(kind_udp_q), .gate_q(gate_q),
        .remain_q(remain_q), .src_q(src_q), .dst_q(dst_q), .ulen_q(ulen_q),
        .ucs_q(ucs_q), .flags_q(flags_q)
    );

    l4chk_csum u_csum (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_byte(in_byte), .csum_seed(csum_seed),
        .sum_ok(sum_ok)
    );

    l4chk_classify #(.LEN_W(LEN_W)) u_classify (
        .clk(clk), .rst_n(rst_n), .last_q(last_q), .kind_udp_q(kind_udp_q),
        .gate_q(gate_q), .remain_q(remain_q), .src_q(src_q), .dst_q(dst_q),
        .ulen_q(ulen_q), .ucs_q(ucs_q), .flags_q(flags_q), .sum_ok(sum_ok),
        .done(done), .err(err), .err_code(err_code)
    );

    // R1: a done strobe always follows an accepted end byte by two edges
    p_done_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && in_eop, 2));

    // R1: results move only together with done
    p_result_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(err) && $stable(err_code)));

endmodule

// File: tb/l4_hdr_check_tb_top.sv
module l4_hdr_check_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_sop, in_eop;
    logic [7:0]  in_byte;
    logic        is_udp, is_frag, prior_err;
    logic [15:0] ip_remain, csum_seed;
    logic        done, err;
    logic [3:0]  err_code;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] pkt [0:63];

    always #5 clk = ~clk;

    l4_hdr_check dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_byte(in_byte), .is_udp(is_udp),
        .ip_remain(ip_remain), .is_frag(is_frag), .prior_err(prior_err),
        .csum_seed(csum_seed), .done(done), .err(err), .err_code(err_code)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fold_sum(input int len, input logic [15:0] seed);
        int unsigned s;
        s = seed;
        for (int i = 0; i < len; i += 2)
            s += {pkt[i], (i + 1 < len) ? pkt[i+1] : 8'h00};
        while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
        return s[15:0];
    endfunction

    // Place a correct checksum in the field for this header type
    task automatic fix_csum(input bit udp, input int len, input logic [15:0] seed);
        int o;
        logic [15:0] v;
        o = udp ? 6 : 16;
        pkt[o] = 8'h00; pkt[o+1] = 8'h00;
        v = ~fold_sum(len, seed);
        pkt[o] = v[15:8]; pkt[o+1] = v[7:0];
    endtask

    // Fill a header with nonzero ports and patterned filler
    task automatic mk(input int len, input logic [15:0] sp, input logic [15:0] dp);
        for (int i = 0; i < 64; i++) pkt[i] = 8'(i * 7 + 3);
        pkt[0] = sp[15:8]; pkt[1] = sp[7:0];
        pkt[2] = dp[15:8]; pkt[3] = dp[7:0];
    endtask

    // Expected code from the requirements
    function automatic logic [3:0] model(input bit udp, input int len,
                                         input logic [15:0] rem, input logic [15:0] seed);
        logic [5:0] f;
        bit ok;
        f  = pkt[13][5:0];
        ok = (fold_sum(len, seed) == 16'hFFFF) || (udp && {pkt[6], pkt[7]} == 16'd0);
        if (!ok) return 4'd2;
        if (udp && {pkt[4], pkt[5]} > rem) return 4'd3;
        if ({pkt[0], pkt[1]} == 16'd0 || {pkt[2], pkt[3]} == 16'd0) return 4'd4;
        if (udp) return 4'd0;
        if (f == 6'd1) return 4'd8;
        if (f == 6'd0) return 4'd9;
        if (f[0] && f[2]) return 4'd10;
        if (f[1] && f[5]) return 4'd11;
        if (f[1] && f[2]) return 4'd12;
        if (f[1] && f[0]) return 4'd13;
        return 4'd0;
    endfunction

    // Stream one header; disturb changes the side inputs after the start byte
    task automatic send(input int len, input bit udp, input logic [15:0] rem,
                        input bit frag, input bit prior, input logic [15:0] seed,
                        input bit disturb);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_byte = pkt[i];
            in_sop = (i == 0); in_eop = (i == len - 1);
            if (i == 0) begin
                is_udp = udp; ip_remain = rem; is_frag = frag;
                prior_err = prior; csum_seed = seed;
            end else if (disturb) begin
                is_udp = !udp; ip_remain = 16'd0; is_frag = 1'b1;
                prior_err = 1'b1; csum_seed = ~seed;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    // Send, then check the strobe cycle, the drop of done and the held result
    task automatic run(input string req, input int len, input bit udp,
                       input logic [15:0] rem, input bit frag, input bit prior,
                       input logic [15:0] seed, input bit disturb);
        logic [3:0] ec;
        ec = (frag || prior) ? 4'd0 : model(udp, len, rem, seed);
        send(len, udp, rem, frag, prior, seed, disturb);
        @(negedge clk);
        chk({req, " done"}, {4'd0, done}, 5'd1);
        chk({req, " code"}, {err, err_code}, {ec != 4'd0, ec});
        @(negedge clk);
        chk("R1 done pulse", {4'd0, done}, 5'd0);
        chk("R1 result held", {err, err_code}, {ec != 4'd0, ec});
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        in_byte = '0; is_udp = 1'b0; is_frag = 1'b0; prior_err = 1'b0;
        ip_remain = '0; csum_seed = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset", {err, err_code}, 5'd0);
        chk("R10 reset done", {4'd0, done}, 5'd0);

        // R7 R8: every combination of the six low flag bits, upper bits varied
        for (int f = 0; f < 64; f++) begin
            mk(20, 16'h1F90 + 16'(f), 16'h0050);
            pkt[13] = {2'(f), 6'(f)};
            fix_csum(0, 20, 16'h1234 + 16'(f));
            run("R7/R8 flag sweep", 20, 0, 16'd40, 0, 0, 16'h1234 + 16'(f), 0);
        end

        // R3: odd-length TCP header, good then bad checksum
        mk(21, 16'h0400, 16'h0401); pkt[13] = 8'h10;
        fix_csum(0, 21, 16'hBEEF);
        run("R3 odd good", 21, 0, 16'd60, 0, 0, 16'hBEEF, 0);
        run("R3 odd bad seed", 21, 0, 16'd60, 0, 0, 16'hBEEE, 0);

        // R9: stacked faults on TCP
        mk(20, 16'h0000, 16'h0050); pkt[13] = 8'h00;
        fix_csum(0, 20, 16'h0F0F);
        run("R9 port over flags", 20, 0, 16'd40, 0, 0, 16'h0F0F, 0);
        run("R9 csum over port", 20, 0, 16'd40, 0, 0, 16'h0F0E, 0);
        mk(20, 16'h1111, 16'h0000); pkt[13] = 8'h03;
        fix_csum(0, 20, 16'h0001);
        run("R6 dst zero tcp", 20, 0, 16'd40, 0, 0, 16'h0001, 0);

        // R5: UDP length stepped across the remaining byte count
        for (int d = -2; d <= 2; d++) begin
            mk(8, 16'h0035, 16'hC000);
            {pkt[4], pkt[5]} = 16'(100 + d);
            fix_csum(1, 8, 16'h5A5A);
            run("R5 udp length", 8, 1, 16'd100, 0, 0, 16'h5A5A, 0);
        end
        mk(8, 16'h0035, 16'hC000); {pkt[4], pkt[5]} = 16'hFFFF;
        fix_csum(1, 8, 16'h0000);
        run("R5 udp length max", 8, 1, 16'hFFFE, 0, 0, 16'h0000, 0);

        // R4: zero UDP checksum skips check; nonzero wrong one reports 2
        mk(8, 16'h0035, 16'hC000); {pkt[4], pkt[5]} = 16'd8; pkt[6] = 8'h00; pkt[7] = 8'h00;
        run("R4 udp csum zero skip", 8, 1, 16'd8, 0, 0, 16'h1357, 0);
        pkt[6] = 8'h12; pkt[7] = 8'h34;
        run("R3 udp csum wrong", 8, 1, 16'd8, 0, 0, 16'h1357, 0);
        // R9: UDP length over port fault
        mk(8, 16'h0000, 16'hC000); {pkt[4], pkt[5]} = 16'd50;
        fix_csum(1, 8, 16'h2222);
        run("R9 ulen over port", 8, 1, 16'd20, 0, 0, 16'h2222, 0);
        // R6: UDP zero source port
        {pkt[4], pkt[5]} = 16'd8; fix_csum(1, 8, 16'h2222);
        run("R6 udp src zero", 8, 1, 16'd20, 0, 0, 16'h2222, 0);

        // R2: fragments and prior errors with every fault present
        mk(20, 16'h0000, 16'h0000); pkt[13] = 8'h00;
        run("R2 fragment", 20, 0, 16'd0, 1, 0, 16'h0000, 0);
        run("R2 prior error", 20, 0, 16'd0, 0, 1, 16'h0000, 0);
        mk(8, 16'h0000, 16'h0000); {pkt[4], pkt[5]} = 16'hFFFF;
        run("R2 udp fragment", 8, 1, 16'd0, 1, 1, 16'h9999, 0);

        // R11: side inputs changed after the start byte are ignored
        mk(20, 16'h2000, 16'h3000); pkt[13] = 8'h07;
        fix_csum(0, 20, 16'h4321);
        run("R11 side inputs late change", 20, 0, 16'd40, 0, 0, 16'h4321, 1);
        mk(8, 16'h0035, 16'hC000); {pkt[4], pkt[5]} = 16'd30;
        fix_csum(1, 8, 16'h7777);
        run("R11 udp late change", 8, 1, 16'd30, 0, 0, 16'h7777, 1);

        // R10: clean TCP header (ACK only)
        mk(20, 16'h0016, 16'hD431); pkt[13] = 8'h10;
        fix_csum(0, 20, 16'hAAAA);
        run("R10 clean tcp", 20, 0, 16'd40, 0, 0, 16'hAAAA, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule